// File: doc/BRIEF.md
# Four-Thread Interleaved Pipeline Core

This block is a 32-bit integer core with a five-stage pipeline: fetch, decode with register read, execute, memory access and write-back. Each stage takes one clock cycle. Four hardware threads share the pipeline. Every thread has its own program counter and its own set of sixteen registers. The fetch stage serves a different thread on every cycle, in a fixed rotation 0, 1, 2, 3, 0 and onward. Because of this, two instructions from the same thread are never in the pipeline at the same time. A thread's next instruction starts only after its previous instruction has written back, so the core needs neither forwarding paths nor interlocks. A load can be followed at once by an instruction that uses its result.

A 2-bit thread tag travels with each instruction through every pipeline register. The tag selects the register set that decode reads and the register set that write-back writes. A branch is resolved in the memory stage and changes only its own thread's program counter. This happens before that thread fetches again, so the core never fetches an instruction from the wrong path.

The core reads instruction memory through one port and data memory through another. Both memories return read data in the same cycle as the address (combinational read). Neither port has a handshake and the core never stalls, so the memories cannot apply back-pressure. An instruction or data word must always be available in the cycle it is addressed.

Top module: `tcore_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `imem_addr` equals thread 0's start address, and `dmem_we` stays low during reset. Every register of every thread resets to zero, and each thread's PC resets to its own start address parameter.
- R2: Fetch addresses follow the thread order 0, 1, 2, 3 and then repeat. A thread's PC grows by 4 at each of its fetches unless one of its branches is taken.
- R3: An instruction reads a register that its own thread's previous instruction wrote, including a value just loaded from memory. It gets the new value with no stall. No two instructions of one thread are ever in flight together.
- R4: Instruction word fields are opcode [31:28], rd [27:24], rs [23:20], rt [19:16] and imm [15:0]. The opcodes are 1 add, 2 sub (rs minus rt, modulo 2^32), 3 and, 4 or and 5 xor, each writing rd. Opcode 0 does nothing.
- R5: Opcode 6 writes rd with rs xor the zero-extended imm.
- R6: Opcode 7 loads rd from address rs plus the sign-extended imm. Opcode 8 stores rt to that address, with `dmem_we` high for one cycle. `dmem_we` and `dmem_re` are never high together.
- R7: Opcode 9 compares rs with rt. If they are equal, it sets its thread's PC to its own address + 4 + (sign-extended imm × 4). An instruction that the branch skips never reaches memory.
- R8: Register 0 of every thread reads as zero, and writes to it are dropped.
- R9: Register sets are private. The same register number in different threads holds independent values.
- R10: Opcodes 10 to 15 change no register and write no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address of the data access in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The assertions rely on several properties of the inputs. Memory read data must be valid in the same cycle as its address. Each thread's start address must be word aligned. Four threads must be configured, so that a thread's branch update and that thread's next fetch fall on different cycles. The stimulus places each thread's program at its own word-aligned start address. It ends each program in a branch to itself, and it gives each thread a disjoint data region. For these reasons, the order of accesses between threads never changes a result, and a sequential per-thread reference model predicts the final memory exactly.

// File: rtl/tcore_pkg.sv
package tcore_pkg;
  localparam int ILEN  = 32;
  localparam int NREG  = 16;
  localparam int RAW   = $clog2(NREG);

  typedef enum logic [3:0] {
    OPC_NOP  = 4'd0, OPC_ADD = 4'd1, OPC_SUB  = 4'd2, OPC_AND = 4'd3,
    OPC_OR   = 4'd4, OPC_XOR = 4'd5, OPC_XORI = 4'd6, OPC_LD  = 4'd7,
    OPC_ST   = 4'd8, OPC_BEQ = 4'd9
  } opc_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
  } fn_e;

  typedef struct packed {
    logic use_imm;
    logic imm_zext;
    fn_e  fn;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  typedef struct packed {
    logic from_mem;
    logic wr_reg;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_t;
endpackage

// File: rtl/tcore_decode.sv
module tcore_decode
  import tcore_pkg::*;
(
  input  logic [3:0] opcode,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    case (opc_e'(opcode))
      OPC_ADD:  begin ctl.ex.fn = FN_ADD; ctl.wb.wr_reg = 1'b1; end
      OPC_SUB:  begin ctl.ex.fn = FN_SUB; ctl.wb.wr_reg = 1'b1; end
      OPC_AND:  begin ctl.ex.fn = FN_AND; ctl.wb.wr_reg = 1'b1; end
      OPC_OR:   begin ctl.ex.fn = FN_OR;  ctl.wb.wr_reg = 1'b1; end
      OPC_XOR:  begin ctl.ex.fn = FN_XOR; ctl.wb.wr_reg = 1'b1; end
      OPC_XORI: begin
        ctl.ex.fn = FN_XOR; ctl.ex.use_imm = 1'b1; ctl.ex.imm_zext = 1'b1;
        ctl.wb.wr_reg = 1'b1;
      end
      OPC_LD: begin
        ctl.ex.fn = FN_ADD; ctl.ex.use_imm = 1'b1; ctl.mem.rd_en = 1'b1;
        ctl.wb.from_mem = 1'b1; ctl.wb.wr_reg = 1'b1;
      end
      OPC_ST: begin
        ctl.ex.fn = FN_ADD; ctl.ex.use_imm = 1'b1; ctl.mem.wr_en = 1'b1;
      end
      OPC_BEQ: ctl.mem.branch = 1'b1;
      default: ctl = '0;
    endcase
  end

  // R10: an unlisted opcode must leave every side effect off
  always_comb begin
    if (opcode > 4'd9)
      a_r10_undef_inert: assert (ctl.wb.wr_reg == 1'b0 && ctl.mem.wr_en == 1'b0);
  end
endmodule

// File: rtl/tcore_alu.sv
module tcore_alu
  import tcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  fn_e             fn,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (fn)
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/tcore_regbank.sv
module tcore_regbank
  import tcore_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NTHREAD = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NTHREAD)-1:0] rtid,
  input  logic [RAW-1:0]             ra1,
  input  logic [RAW-1:0]             ra2,
  output logic [XLEN-1:0]            rd1,
  output logic [XLEN-1:0]            rd2,
  input  logic                       we,
  input  logic [$clog2(NTHREAD)-1:0] wtid,
  input  logic [RAW-1:0]             wa,
  input  logic [XLEN-1:0]            wd
);
  localparam int TW = $clog2(NTHREAD);

  logic [XLEN-1:0] port1_t [NTHREAD];
  logic [XLEN-1:0] port2_t [NTHREAD];

  for (genvar g = 0; g < NTHREAD; g++) begin : g_set
    logic [XLEN-1:0] bank_q [NREG];
    logic            hit;
    assign hit = we && (wtid == TW'(g)) && (wa != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NREG; r++) bank_q[r] <= '0;
      end else if (hit) begin
        bank_q[wa] <= wd;
      end
    end

    assign port1_t[g] = bank_q[ra1];
    assign port2_t[g] = bank_q[ra2];

    // R8: register 0 storage stays zero whatever write-back presents
    a_r8_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
      bank_q[0] == '0);
    // R9: a write to this thread's set lands in this set
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wtid == TW'(g) && wa != '0) |=> bank_q[$past(wa)] == $past(wd));
  end

  assign rd1 = (ra1 == '0) ? '0 : port1_t[rtid];
  assign rd2 = (ra2 == '0) ? '0 : port2_t[rtid];
endmodule

// File: rtl/tcore_top.sv
module tcore_top
  import tcore_pkg::*;
#(
  parameter int                      XLEN     = 32,
  parameter int                      NTHREAD  = 4,
  parameter logic [NTHREAD*XLEN-1:0] START_PC = {32'h300, 32'h200, 32'h100, 32'h000}
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int TW   = $clog2(NTHREAD);
  localparam int IMMW = 16;

  // ---------------- fetch ----------------
  logic [TW-1:0]   fetch_tid_q;
  logic [XLEN-1:0] pc_q [NTHREAD];

  logic            ifid_v;
  logic [TW-1:0]   ifid_tid;
  logic [XLEN-1:0] ifid_pc;
  logic [ILEN-1:0] ifid_ins;

  logic            idex_v;
  logic [TW-1:0]   idex_tid;
  logic [XLEN-1:0] idex_pc;
  ctl_t            idex_ctl;
  logic [RAW-1:0]  idex_rd;
  logic [XLEN-1:0] idex_a, idex_b, idex_imm;

  logic            exmem_v;
  logic [TW-1:0]   exmem_tid;
  mem_ctl_t        exmem_mctl;
  wb_ctl_t         exmem_wctl;
  logic [RAW-1:0]  exmem_rd;
  logic [XLEN-1:0] exmem_y, exmem_sd, exmem_tgt;
  logic            exmem_take;

  logic            memwb_v;
  logic [TW-1:0]   memwb_tid;
  wb_ctl_t         memwb_wctl;
  logic [RAW-1:0]  memwb_rd;
  logic [XLEN-1:0] memwb_data;

  assign imem_addr = pc_q[fetch_tid_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_tid_q <= '0;
      for (int t = 0; t < NTHREAD; t++) pc_q[t] <= START_PC[t*XLEN +: XLEN];
    end else begin
      fetch_tid_q <= (fetch_tid_q == TW'(NTHREAD-1)) ? '0 : fetch_tid_q + 1'b1;
      for (int t = 0; t < NTHREAD; t++) begin
        if (exmem_v && exmem_take && exmem_tid == TW'(t))
          pc_q[t] <= exmem_tgt;
        else if (fetch_tid_q == TW'(t))
          pc_q[t] <= pc_q[t] + XLEN'(4);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid_v <= 1'b0; ifid_tid <= '0; ifid_pc <= '0; ifid_ins <= '0;
    end else begin
      ifid_v <= 1'b1; ifid_tid <= fetch_tid_q; ifid_pc <= imem_addr; ifid_ins <= imem_rdata;
    end
  end

  // ---------------- decode ----------------
  ctl_t            dec_ctl;
  logic [XLEN-1:0] rs_val, rt_val, imm_ext;
  logic            wb_we;
  logic [XLEN-1:0] wb_data;

  tcore_decode u_dec (.opcode(ifid_ins[31:28]), .ctl(dec_ctl));

  assign wb_we   = memwb_v && memwb_wctl.wr_reg;
  assign wb_data = memwb_data;

  tcore_regbank #(.XLEN(XLEN), .NTHREAD(NTHREAD)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rtid(ifid_tid), .ra1(ifid_ins[23:20]), .ra2(ifid_ins[19:16]),
    .rd1(rs_val), .rd2(rt_val),
    .we(wb_we), .wtid(memwb_tid), .wa(memwb_rd), .wd(wb_data)
  );

  assign imm_ext = dec_ctl.ex.imm_zext
                 ? {{(XLEN-IMMW){1'b0}}, ifid_ins[15:0]}
                 : {{(XLEN-IMMW){ifid_ins[15]}}, ifid_ins[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_v <= 1'b0; idex_tid <= '0; idex_pc <= '0; idex_ctl <= '0;
      idex_rd <= '0; idex_a <= '0; idex_b <= '0; idex_imm <= '0;
    end else begin
      idex_v <= ifid_v; idex_tid <= ifid_tid; idex_pc <= ifid_pc;
      idex_ctl <= ifid_v ? dec_ctl : '0;
      idex_rd <= ifid_ins[27:24]; idex_a <= rs_val; idex_b <= rt_val;
      idex_imm <= imm_ext;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] alu_y;

  tcore_alu #(.XLEN(XLEN)) u_alu (
    .a(idex_a), .b(idex_ctl.ex.use_imm ? idex_imm : idex_b),
    .fn(idex_ctl.ex.fn), .y(alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exmem_v <= 1'b0; exmem_tid <= '0; exmem_mctl <= '0; exmem_wctl <= '0;
      exmem_rd <= '0; exmem_y <= '0; exmem_sd <= '0; exmem_tgt <= '0;
      exmem_take <= 1'b0;
    end else begin
      exmem_v <= idex_v; exmem_tid <= idex_tid;
      exmem_mctl <= idex_ctl.mem; exmem_wctl <= idex_ctl.wb;
      exmem_rd <= idex_rd; exmem_y <= alu_y; exmem_sd <= idex_b;
      exmem_tgt <= idex_pc + XLEN'(4) + (idex_imm << 2);
      exmem_take <= idex_ctl.mem.branch && (idex_a == idex_b);
    end
  end

  // ---------------- memory ----------------
  assign dmem_addr  = exmem_y;
  assign dmem_wdata = exmem_sd;
  assign dmem_we    = exmem_v && exmem_mctl.wr_en;
  assign dmem_re    = exmem_v && exmem_mctl.rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memwb_v <= 1'b0; memwb_tid <= '0; memwb_wctl <= '0; memwb_rd <= '0;
      memwb_data <= '0;
    end else begin
      memwb_v <= exmem_v; memwb_tid <= exmem_tid; memwb_wctl <= exmem_wctl;
      memwb_rd <= exmem_rd;
      memwb_data <= exmem_wctl.from_mem ? dmem_rdata : exmem_y;
    end
  end

  // ---------------- checks ----------------
  // R3: the four in-flight instructions always belong to four different threads
  a_r3_threads_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !((ifid_v && idex_v && ifid_tid == idex_tid) ||
      (ifid_v && exmem_v && ifid_tid == exmem_tid) ||
      (ifid_v && memwb_v && ifid_tid == memwb_tid) ||
      (idex_v && exmem_v && idex_tid == exmem_tid) ||
      (idex_v && memwb_v && idex_tid == memwb_tid) ||
      (exmem_v && memwb_v && exmem_tid == memwb_tid)));
  // R6: load and store strobes never overlap
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));
  // R6: loaded word reaches write-back unchanged
  a_r6_load_carried: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_v && exmem_mctl.rd_en) |=> memwb_data == $past(dmem_rdata));
  // R7: taken branch sets its own thread's PC before that thread fetches again
  a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_v && exmem_take) |=> pc_q[$past(exmem_tid)] == $past(exmem_tgt));
  // R2: fetch slot moves to the following thread every cycle
  a_r2_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_v |-> ifid_tid != fetch_tid_q);
endmodule

// File: tb/tcore_top_bench.sv
`timescale 1ns/1ps
module tcore_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] mdmem [256];
  logic [31:0] mregs [4][16];

  int total = 0;
  int bad   = 0;
  int overlap = 0;
  int rst_we  = 0;

  localparam logic [31:0] STARTS [4] = '{32'h000, 32'h100, 32'h200, 32'h300};
  // vectors: expected fetch address on each cycle after reset release (R1, R2)
  localparam logic [31:0] FETCH_EXP [8] = '{
    32'h000, 32'h100, 32'h200, 32'h300, 32'h004, 32'h104, 32'h204, 32'h304};

  always #2.5 clk = ~clk;

  tcore_top u_tcore_top (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  always @(negedge clk) begin
    if (rst_n && dmem_we && dmem_re) overlap++;
    if (!rst_n && dmem_we) rst_we++;
  end

  function automatic logic [31:0] enc(input logic [3:0] op, input int rd, input int rs,
                                      input int rt, input logic [15:0] imm);
    return {op, 4'(rd), 4'(rs), 4'(rt), imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_programs();
    for (int i = 0; i < 256; i++) begin imem[i] = '0; dmem[i] = '0; end
    dmem[0] = 32'h11; dmem[1] = 32'h22;
    // thread 0: loads feeding the very next instruction (R3, R6)
    imem[0]  = enc(7, 1, 0, 0, 16'h0);
    imem[1]  = enc(1, 2, 1, 1, 0);
    imem[2]  = enc(7, 3, 0, 0, 16'h4);
    imem[3]  = enc(2, 4, 3, 1, 0);
    imem[4]  = enc(6, 5, 2, 0, 16'h8001);
    imem[5]  = enc(8, 0, 0, 2, 16'h100);
    imem[6]  = enc(8, 0, 0, 4, 16'h104);
    imem[7]  = enc(8, 0, 0, 5, 16'h108);
    imem[8]  = enc(7, 6, 0, 0, 16'h100);
    imem[9]  = enc(1, 7, 6, 6, 0);
    imem[10] = enc(8, 0, 0, 7, 16'h10C);
    imem[11] = enc(9, 0, 0, 0, 16'hFFFF);
    // thread 1: r0 write, undefined opcode, and/or (R4, R8, R10)
    imem[64] = enc(6, 0, 0, 0, 16'h0055);
    imem[65] = enc(6, 1, 0, 0, 16'h0F0F);
    imem[66] = enc(15, 1, 0, 1, 16'h1234);
    imem[67] = enc(6, 2, 0, 0, 16'h00FF);
    imem[68] = enc(3, 3, 1, 2, 0);
    imem[69] = enc(4, 4, 1, 2, 0);
    imem[70] = enc(8, 0, 0, 0, 16'h140);
    imem[71] = enc(8, 0, 0, 1, 16'h144);
    imem[72] = enc(8, 0, 0, 3, 16'h148);
    imem[73] = enc(8, 0, 0, 4, 16'h14C);
    imem[74] = enc(9, 0, 0, 0, 16'hFFFF);
    // thread 2: taken, not-taken and backward branches (R7)
    imem[128] = enc(6, 1, 0, 0, 16'd5);
    imem[129] = enc(6, 2, 0, 0, 16'd5);
    imem[130] = enc(9, 0, 1, 2, 16'd1);
    imem[131] = enc(8, 0, 0, 1, 16'h180);
    imem[132] = enc(6, 3, 0, 0, 16'd7);
    imem[133] = enc(9, 0, 1, 3, 16'd1);
    imem[134] = enc(8, 0, 0, 3, 16'h184);
    imem[135] = enc(8, 0, 0, 1, 16'h188);
    imem[136] = enc(6, 6, 0, 0, 16'd1);
    imem[137] = enc(6, 5, 0, 0, 16'd3);
    imem[138] = enc(1, 4, 4, 6, 0);
    imem[139] = enc(9, 0, 4, 5, 16'd1);
    imem[140] = enc(9, 0, 0, 0, 16'hFFFD);
    imem[141] = enc(8, 0, 0, 4, 16'h18C);
    imem[142] = enc(9, 0, 0, 0, 16'hFFFF);
    // thread 3: same register numbers as thread 0, own values (R9)
    imem[192] = enc(6, 1, 0, 0, 16'h3333);
    imem[193] = enc(6, 2, 0, 0, 16'h0101);
    imem[194] = enc(5, 3, 1, 2, 0);
    imem[195] = enc(8, 0, 0, 3, 16'h1C0);
    imem[196] = enc(8, 0, 0, 1, 16'h1C4);
    imem[197] = enc(8, 0, 0, 2, 16'h1C8);
    imem[198] = enc(2, 4, 0, 2, 0);
    imem[199] = enc(8, 0, 0, 4, 16'h1CC);
    imem[200] = enc(9, 0, 0, 0, 16'hFFFF);
  endtask

  // sequential reference model, one thread after another
  task automatic run_model();
    for (int i = 0; i < 256; i++) mdmem[i] = (i == 0) ? 32'h11 : (i == 1) ? 32'h22 : 32'h0;
    for (int t = 0; t < 4; t++) begin
      logic [31:0] pc;
      for (int r = 0; r < 16; r++) mregs[t][r] = '0;
      pc = STARTS[t];
      for (int s = 0; s < 300; s++) begin
        logic [31:0] ins, a, b, sx, zx, res, nxt;
        logic [3:0]  op;
        logic        wr;
        ins = imem[pc[9:2]];
        op  = ins[31:28];
        a   = mregs[t][ins[23:20]];
        b   = mregs[t][ins[19:16]];
        sx  = {{16{ins[15]}}, ins[15:0]};
        zx  = {16'h0, ins[15:0]};
        nxt = pc + 4; wr = 1'b0; res = '0;
        case (op)
          4'd1: begin res = a + b; wr = 1'b1; end
          4'd2: begin res = a - b; wr = 1'b1; end
          4'd3: begin res = a & b; wr = 1'b1; end
          4'd4: begin res = a | b; wr = 1'b1; end
          4'd5: begin res = a ^ b; wr = 1'b1; end
          4'd6: begin res = a ^ zx; wr = 1'b1; end
          4'd7: begin res = mdmem[(a + sx) >> 2 & 32'hFF]; wr = 1'b1; end
          4'd8: mdmem[(a + sx) >> 2 & 32'hFF] = b;
          4'd9: if (a == b) nxt = pc + 4 + (sx << 2);
          default: ;
        endcase
        if (wr && ins[27:24] != 4'd0) mregs[t][ins[27:24]] = res;
        if (nxt == pc) break;
        pc = nxt;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    load_programs();
    run_model();
    repeat (3) @(negedge clk);
    chk("R1 reset fetch address", imem_addr, 32'h000);
    rst_n = 1'b1;
    #0.5;
    for (int i = 0; i < 8; i++) begin
      chk(i < 1 ? "R1 first fetch" : "R2 fetch rotation", imem_addr, FETCH_EXP[i]);
      @(negedge clk);
    end
    repeat (600) @(negedge clk);
    chk("R1 no store during reset", 32'(rst_we), 0);
    // directed expected values
    chk("R3 load then dependent add", dmem[64], 32'h22);
    chk("R3 second load used at once", dmem[65], 32'h11);
    chk("R5 xori zero-extends", dmem[66], 32'h8023);
    chk("R3 load of own store", dmem[67], 32'h44);
    chk("R8 r0 reads zero after write", dmem[80], 32'h0);
    chk("R10 undefined opcode no effect", dmem[81], 32'h0F0F);
    chk("R10 undefined opcode no store", dmem[141], 32'h0);
    chk("R4 and", dmem[82], 32'h000F);
    chk("R4 or", dmem[83], 32'h0FFF);
    chk("R7 skipped store absent", dmem[96], 32'h0);
    chk("R7 not-taken falls through", dmem[97], 32'h7);
    chk("R7 after taken branch", dmem[98], 32'h5);
    chk("R7 backward loop count", dmem[99], 32'h3);
    chk("R9 private xor result", dmem[112], 32'h3232);
    chk("R9 private r2 value", dmem[114], 32'h0101);
    chk("R4 sub wraps", dmem[115], 32'hFFFF_FEFF);
    chk("R6 strobes never overlap", 32'(overlap), 0);
    for (int i = 0; i < 256; i++) chk("R6 memory matches model", dmem[i], mdmem[i]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule